// File: doc/BRIEF.md
# Time-Multiplexed Audio Link Frame Controller

This block is the host end of a five-wire serial audio link. The codec supplies the bit clock. The block divides that clock into frames of 256 bits, drives the frame strobe, and shifts one outgoing frame onto the serial output while it shifts one incoming frame in from the serial input. Each frame starts with a 16-bit tag phase. Twelve 20-bit slots follow it. New serial data is launched on the rising clock edge, and incoming data is sampled on the falling edge.

On the parallel side the block takes a register command and a stereo playback sample pair. The register command is a read/write flag, a 7-bit register index and 16 bits of write data. These values are captured once per frame, at the edge that launches the first tag bit. Each frame also returns a register read-back and a stereo record sample pair. The read-back is a register index and 16 bits of data. Each returned item has its own one-cycle valid pulse, and the pulse fires only when the codec marked that slot valid in its tag.

Top module: `tdm_link_frame_ctrl`

## Requirements
- R1: A frame is 256 bit clocks long. `syncOut` is high for frame positions 0 to 15 (the tag phase) and low for positions 16 to 255, and this pattern repeats without gaps.
- R2: While `rstN` is low, `syncOut`, `sdataOut` and all four valid outputs are 0. The first rising edge after reset is released launches position 0 of the first frame. No valid pulse fires before one full frame has been received.
- R3: Outgoing tag layout. Bit 15 (position 0) is always 1. Bits 14 and 13 (slots 1 and 2) equal the captured `cmdValid`. Bits 12 and 11 (slots 3 and 4) equal the captured `pcmValid`. Bits 10 to 0 are 0.
- R4: Outgoing slot 1 has bit 19 = `cmdRead`, bits 18..12 = `cmdIndex` and bits 11..0 = 0. Outgoing slot 2 has bits 19..4 = `cmdWrData` and bits 3..0 = 0.
- R5: Outgoing slots 3 and 4 carry `pcmLeft` and `pcmRight` in bits 19..4 with bits 3..0 = 0. Every field goes out most significant bit first: tag bit 15 at position 0, and slot n bit 19 at position 16 + 20·(n−1).
- R6: Outgoing slots 5 to 12 (positions 96 to 255) are all 0.
- R7: Parallel inputs are captured at the rising edge that launches position 0. Changing them later in the frame does not alter the frame being sent.
- R8: `sdataOut` changes only on rising edges. `sdataIn` is sampled on the falling edge inside each bit period, so its value around the rising edge has no effect.
- R9: Incoming tag bits 14, 13, 12 and 11 gate the valid pulses of slots 1 to 4 (`statIdxValid`, `statDataValid`, `recLeftValid`, `recRightValid`). A pulse is one cycle wide and occurs during position 0 of the next frame, after position 255 has been sampled.
- R10: `statIdx` = incoming slot 1 bits 18..12. `statData`, `recLeft` and `recRight` = bits 19..4 of incoming slots 2, 3 and 4. Incoming slots 5 to 12, the other tag bits and the unused slot bits do not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock from the codec |
| rstN | input | 1 | Asynchronous active-low reset |
| syncOut | output | 1 | Frame strobe, high during the tag phase |
| sdataOut | output | 1 | Serial data to the codec |
| sdataIn | input | 1 | Serial data from the codec |
| cmdValid | input | 1 | Command slots carry valid data this frame |
| cmdRead | input | 1 | 1 = register read, 0 = register write |
| cmdIndex | input | 7 | Register index of the command |
| cmdWrData | input | 16 | Register write data |
| pcmValid | input | 1 | Playback slots carry valid data this frame |
| pcmLeft | input | 16 | Left playback sample |
| pcmRight | input | 16 | Right playback sample |
| statIdxValid | output | 1 | One-cycle strobe for `statIdx` |
| statIdx | output | 7 | Register index returned by the codec |
| statDataValid | output | 1 | One-cycle strobe for `statData` |
| statData | output | 16 | Register read-back data |
| recLeftValid | output | 1 | One-cycle strobe for `recLeft` |
| recLeft | output | 16 | Left record sample |
| recRightValid | output | 1 | One-cycle strobe for `recRight` |
| recRight | output | 16 | Right record sample |

## Verification
The bench plays the codec. It drives every incoming bit just after the rising edge and inverts it just after the falling edge. A design that samples on the wrong edge therefore collects inverted data and fails the read-back checks. The next frame's parallel inputs are changed 20 bits into the current frame, so a design that reads its inputs live instead of capturing them would corrupt slots 1 to 4. Incoming frames carry random junk in slots 5 to 12, in the pad bits and in the unused tag bits, and they cycle through all-set, all-clear and alternating slot-valid patterns. Any leak of junk, or a pulse that ignores its tag bit, shows up as a wrong value or a wrong strobe. Frame-strobe width, wrap length, the tag layout and the first frame after reset are compared bit by bit, which catches off-by-one counters and a first frame started one edge late.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;
  localparam int TAG_BITS    = 16;
  localparam int SLOT_BITS   = 20;
  localparam int NUM_SLOTS   = 12;
  localparam int SAMPLE_BITS = 16;
  localparam int IDX_BITS    = 7;
  localparam int USED_SLOTS  = 4;
  localparam int FRAME_BITS  = TAG_BITS + SLOT_BITS * NUM_SLOTS;
  localparam int SLOT_W      = $clog2(NUM_SLOTS + 1);
  localparam int BIT_W       = $clog2(SLOT_BITS);

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic              launchStart; // next rising edge launches position 0
    logic [SLOT_W-1:0] launchSlot;  // 0 = tag, 1..NUM_SLOTS = data slot
    logic [BIT_W-1:0]  launchBit;   // bit index inside field, counting down
    logic              capEn;       // current position holds a live bit
    logic [SLOT_W-1:0] capSlot;
    logic [BIT_W-1:0]  capBit;
    logic              capEnd;      // current position is the last of a frame
  } seqStrobe_t;
endpackage

// File: rtl/tdm_link_seq.sv
module tdm_link_seq
  import tdm_link_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  output seqStrobe_t strb,
  output logic       syncOut
);
  localparam int POS_W = $clog2(FRAME_BITS);
  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0]  TAG_END   = POS_W'(TAG_BITS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS);
  localparam logic [BIT_W-1:0]  TAG_TOP   = BIT_W'(TAG_BITS - 1);
  localparam logic [BIT_W-1:0]  SLOT_TOP  = BIT_W'(SLOT_BITS - 1);

  logic              running;
  logic [POS_W-1:0]  pos, nPos;
  logic [SLOT_W-1:0] slot, nSlot;
  logic [BIT_W-1:0]  bitIdx, nBit;

  always_comb begin
    if (!running) begin
      nPos  = '0;
      nSlot = '0;
      nBit  = TAG_TOP;
    end else begin
      nPos = (pos == LAST_POS) ? '0 : pos + 1'b1;
      if (bitIdx != '0) begin
        nSlot = slot;
        nBit  = bitIdx - 1'b1;
      end else if (slot == LAST_SLOT) begin
        nSlot = '0;
        nBit  = TAG_TOP;
      end else begin
        nSlot = slot + 1'b1;
        nBit  = SLOT_TOP;
      end
    end
  end

  always_comb begin
    strb.launchStart = (nPos == '0);
    strb.launchSlot  = nSlot;
    strb.launchBit   = nBit;
    strb.capEn       = running;
    strb.capSlot     = slot;
    strb.capBit      = bitIdx;
    strb.capEnd      = running && (pos == LAST_POS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      pos     <= '0;
      slot    <= '0;
      bitIdx  <= TAG_TOP;
      syncOut <= 1'b0;
    end else begin
      running <= 1'b1;
      pos     <= nPos;
      slot    <= nSlot;
      bitIdx  <= nBit;
      syncOut <= (nPos < TAG_END);
    end
  end

  // R1: strobe opens each frame and closes after the tag phase
  a_r1_sync_open: assert property (@(posedge clk) disable iff (!rstN)
    (running && pos == '0) |-> syncOut);
  a_r1_sync_close: assert property (@(posedge clk) disable iff (!rstN)
    (running && pos == TAG_END) |-> !syncOut);
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (running && pos == LAST_POS) |=> (pos == '0));
  a_r1_slot_align: assert property (@(posedge clk) disable iff (!rstN)
    (running && pos == LAST_POS) |-> (slot == LAST_SLOT && bitIdx == '0));
  // R2: no strobe before the first frame
  a_r2_idle_sync: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !syncOut);
endmodule

// File: rtl/tdm_link_dp.sv
module tdm_link_dp
  import tdm_link_pkg::*;
(
  input  logic                                     clk,
  input  logic                                     rstN,
  input  seqStrobe_t                               strb,
  input  logic                                     sdataIn,
  output logic                                     sdataOut,
  input  logic                                     cmdValid,
  input  logic                                     cmdRead,
  input  logic [IDX_BITS-1:0]                      cmdIndex,
  input  logic [SAMPLE_BITS-1:0]                   cmdWrData,
  input  logic                                     pcmValid,
  input  logic [SAMPLE_BITS-1:0]                   pcmLeft,
  input  logic [SAMPLE_BITS-1:0]                   pcmRight,
  output logic [USED_SLOTS-1:0]                    rxValid,
  output logic [IDX_BITS-1:0]                      statIdx,
  output logic [USED_SLOTS-2:0][SAMPLE_BITS-1:0]   rxSamp
);
  localparam int PAD_BITS  = SLOT_BITS - SAMPLE_BITS;
  localparam int ZERO_LOW  = SLOT_BITS - 1 - IDX_BITS;
  localparam int TAG_IDX_W = $clog2(TAG_BITS);
  localparam logic [BIT_W-1:0]  TAGV_HI = BIT_W'(TAG_BITS - 2);
  localparam logic [BIT_W-1:0]  TAGV_LO = BIT_W'(TAG_BITS - 1 - USED_SLOTS);
  localparam logic [BIT_W-1:0]  IDX_HI  = BIT_W'(SLOT_BITS - 2);
  localparam logic [BIT_W-1:0]  IDX_LO  = BIT_W'(ZERO_LOW);
  localparam logic [BIT_W-1:0]  PAD_LO  = BIT_W'(PAD_BITS);
  localparam logic [SLOT_W-1:0] LAST_USED = SLOT_W'(USED_SLOTS);

  // ---------------- transmit ----------------
  logic                   txCmdV, txRd, txPcmV;
  logic [IDX_BITS-1:0]    txIdx;
  logic [SAMPLE_BITS-1:0] txCmd, txL, txR;
  logic [NUM_SLOTS:1]     slotValid;
  logic [TAG_BITS-1:0]    txTag;
  logic [SLOT_BITS-1:0]   txWord [USED_SLOTS];
  logic                   nextBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCmdV <= 1'b0;
      txRd   <= 1'b0;
      txIdx  <= '0;
      txCmd  <= '0;
      txPcmV <= 1'b0;
      txL    <= '0;
      txR    <= '0;
    end else if (strb.launchStart) begin
      txCmdV <= cmdValid;
      txRd   <= cmdRead;
      txIdx  <= cmdIndex;
      txCmd  <= cmdWrData;
      txPcmV <= pcmValid;
      txL    <= pcmLeft;
      txR    <= pcmRight;
    end
  end

  for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_slotValid
    if (s <= 2) begin : g_cmd
      assign slotValid[s] = txCmdV;
    end else if (s <= USED_SLOTS) begin : g_pcm
      assign slotValid[s] = txPcmV;
    end else begin : g_idle
      assign slotValid[s] = 1'b0;
    end
  end

  always_comb begin
    txTag = '0;
    txTag[TAG_BITS-1] = 1'b1;
    for (int s = 1; s <= NUM_SLOTS; s++) txTag[TAG_BITS-1-s] = slotValid[s];
  end

  assign txWord[0] = {txRd, txIdx, {ZERO_LOW{1'b0}}};
  assign txWord[1] = {txCmd, {PAD_BITS{1'b0}}};
  assign txWord[2] = {txL, {PAD_BITS{1'b0}}};
  assign txWord[3] = {txR, {PAD_BITS{1'b0}}};

  // Position 0 is the constant frame-valid bit, so the old latch is safe there
  always_comb begin
    nextBit = 1'b0;
    if (strb.launchSlot == '0) begin
      nextBit = txTag[strb.launchBit[TAG_IDX_W-1:0]];
    end else begin
      for (int s = 0; s < USED_SLOTS; s++)
        if (strb.launchSlot == SLOT_W'(s + 1)) nextBit = txWord[s][strb.launchBit];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdataOut <= 1'b0;
    else       sdataOut <= nextBit;
  end

  // ---------------- receive ----------------
  logic                  rxSample;
  logic [USED_SLOTS-1:0] rxTagV;   // [USED_SLOTS-1] = slot 1
  logic [IDX_BITS-1:0]   idxShift;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) rxSample <= 1'b0;
    else       rxSample <= sdataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxTagV   <= '0;
      idxShift <= '0;
    end else if (strb.capEn) begin
      if (strb.capSlot == '0 && strb.capBit <= TAGV_HI && strb.capBit >= TAGV_LO)
        rxTagV <= {rxTagV[USED_SLOTS-2:0], rxSample};
      if (strb.capSlot == SLOT_W'(1) && strb.capBit <= IDX_HI && strb.capBit >= IDX_LO)
        idxShift <= {idxShift[IDX_BITS-2:0], rxSample};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid <= '0;
      statIdx <= '0;
    end else begin
      for (int k = 0; k < USED_SLOTS; k++)
        rxValid[k] <= strb.capEnd && rxTagV[USED_SLOTS-1-k];
      if (strb.capEnd && rxTagV[USED_SLOTS-1]) statIdx <= idxShift;
    end
  end

  for (genvar g = 0; g < USED_SLOTS - 1; g++) begin : g_samp
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(g + 2);
    logic [SAMPLE_BITS-1:0] shiftQ, outQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftQ <= '0;
        outQ   <= '0;
      end else begin
        if (strb.capEn && strb.capSlot == MY_SLOT && strb.capBit >= PAD_LO)
          shiftQ <= {shiftQ[SAMPLE_BITS-2:0], rxSample};
        if (strb.capEnd && rxTagV[USED_SLOTS-2-g]) outQ <= shiftQ;
      end
    end
    assign rxSamp[g] = outQ;
  end

  // R3: the frame-valid bit leads every outgoing frame
  a_r3_tag_lead: assert property (@(posedge clk) disable iff (!rstN)
    strb.launchStart |=> sdataOut);
  // R6: unused slots go out as zero
  a_r6_idle_slots: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launchSlot > LAST_USED) |=> !sdataOut);
  // R9: valid strobes last one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid != '0) |=> (rxValid == '0));
endmodule

// File: rtl/tdm_link_frame_ctrl.sv
module tdm_link_frame_ctrl
  import tdm_link_pkg::*;
(
  input  logic                   bitClk,
  input  logic                   rstN,
  output logic                   syncOut,
  output logic                   sdataOut,
  input  logic                   sdataIn,
  input  logic                   cmdValid,
  input  logic                   cmdRead,
  input  logic [IDX_BITS-1:0]    cmdIndex,
  input  logic [SAMPLE_BITS-1:0] cmdWrData,
  input  logic                   pcmValid,
  input  logic [SAMPLE_BITS-1:0] pcmLeft,
  input  logic [SAMPLE_BITS-1:0] pcmRight,
  output logic                   statIdxValid,
  output logic [IDX_BITS-1:0]    statIdx,
  output logic                   statDataValid,
  output logic [SAMPLE_BITS-1:0] statData,
  output logic                   recLeftValid,
  output logic [SAMPLE_BITS-1:0] recLeft,
  output logic                   recRightValid,
  output logic [SAMPLE_BITS-1:0] recRight
);
  seqStrobe_t                             strb;
  logic [USED_SLOTS-1:0]                  rxValid;
  logic [USED_SLOTS-2:0][SAMPLE_BITS-1:0] rxSamp;

  tdm_link_seq u_seq (
    .clk     (bitClk),
    .rstN    (rstN),
    .strb    (strb),
    .syncOut (syncOut)
  );

  tdm_link_dp u_dp (
    .clk       (bitClk),
    .rstN      (rstN),
    .strb      (strb),
    .sdataIn   (sdataIn),
    .sdataOut  (sdataOut),
    .cmdValid  (cmdValid),
    .cmdRead   (cmdRead),
    .cmdIndex  (cmdIndex),
    .cmdWrData (cmdWrData),
    .pcmValid  (pcmValid),
    .pcmLeft   (pcmLeft),
    .pcmRight  (pcmRight),
    .rxValid   (rxValid),
    .statIdx   (statIdx),
    .rxSamp    (rxSamp)
  );

  assign statIdxValid  = rxValid[0];
  assign statDataValid = rxValid[1];
  assign recLeftValid  = rxValid[2];
  assign recRightValid = rxValid[3];
  assign statData      = rxSamp[0];
  assign recLeft       = rxSamp[1];
  assign recRight      = rxSamp[2];

  // R9: read-back strobes only appear while the next frame's tag is going out
  a_r9_in_tag_phase: assert property (@(posedge bitClk) disable iff (!rstN)
    (rxValid != '0) |-> syncOut);
endmodule

// File: tb/test_tdm_link_frame_ctrl.sv
module test_tdm_link_frame_ctrl;
  localparam int NF = 9;

  logic bitClk = 1'b0;
  logic rstN = 1'b0;
  always #4 bitClk = ~bitClk;

  logic        syncOut, sdataOut;
  logic        sdataIn = 1'b0;
  logic        cmdValid = 1'b0, cmdRead = 1'b0, pcmValid = 1'b0;
  logic [6:0]  cmdIndex = '0;
  logic [15:0] cmdWrData = '0, pcmLeft = '0, pcmRight = '0;
  logic        statIdxValid, statDataValid, recLeftValid, recRightValid;
  logic [6:0]  statIdx;
  logic [15:0] statData, recLeft, recRight;

  tdm_link_frame_ctrl i_tdm_link_frame_ctrl (
    .bitClk(bitClk), .rstN(rstN), .syncOut(syncOut), .sdataOut(sdataOut),
    .sdataIn(sdataIn), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .cmdIndex(cmdIndex), .cmdWrData(cmdWrData), .pcmValid(pcmValid),
    .pcmLeft(pcmLeft), .pcmRight(pcmRight), .statIdxValid(statIdxValid),
    .statIdx(statIdx), .statDataValid(statDataValid), .statData(statData),
    .recLeftValid(recLeftValid), .recLeft(recLeft),
    .recRightValid(recRightValid), .recRight(recRight)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  v;
    logic [6:0]  idx;
    logic [15:0] d;
    logic [15:0] l;
    logic [15:0] r;
  } rxExp_t;

  logic [255:0] expTxQ[$];
  rxExp_t       expRxQ[$];
  logic [255:0] curRx = '0;
  logic [255:0] nextRx = '0;

  // ---------------- codec model ----------------
  int   cpos = 0;
  bit   cStarted = 0;
  logic cPrev = 1'b0;
  always @(posedge bitClk) begin
    #1;
    if (syncOut === 1'b1 && cPrev !== 1'b1) begin
      cpos = 0;
      cStarted = 1;
    end else begin
      cpos = (cpos + 1) % 256;
    end
    cPrev = syncOut;
    if (cStarted && cpos == 0) curRx = nextRx;
    sdataIn = cStarted ? curRx[255-cpos] : 1'b0;
  end
  // R8: the bit is wrong around the rising edge, right around the falling edge
  always @(negedge bitClk) begin
    #1;
    sdataIn = ~sdataIn;
  end

  // ---------------- driver ----------------
  task automatic loadFrame(input int f);
    logic       cv, rd, pv;
    logic [6:0] idx;
    logic [15:0] cd, pl, pr;
    logic [3:0]  rv;
    logic [6:0]  ridx;
    logic [15:0] rd16, rl, rr;
    logic [15:0] tag;
    logic [19:0] s1, s2, s3, s4;
    logic [159:0] junk;
    rxExp_t e;
    case (f)
      0: begin cv = 1; rd = 0; idx = 7'h02; cd = 16'h8000; pv = 1; pl = 16'hFFFF; pr = 16'h0001; rv = 4'b1111; end
      1: begin cv = 1; rd = 1; idx = 7'h7F; cd = 16'h0000; pv = 0; pl = 16'h1234; pr = 16'h5678; rv = 4'b0000; end
      2: begin cv = 0; rd = 0; idx = 7'h55; cd = 16'hA5A5; pv = 1; pl = 16'h8001; pr = 16'h7FFE; rv = 4'b1010; end
      3: begin cv = 0; rd = 1; idx = 7'h2A; cd = 16'h5A5A; pv = 0; pl = 16'hC3C3; pr = 16'h3C3C; rv = 4'b0101; end
      default: begin
        cv = 1'($urandom); rd = 1'($urandom); idx = 7'($urandom); cd = 16'($urandom);
        pv = 1'($urandom); pl = 16'($urandom); pr = 16'($urandom); rv = 4'($urandom);
      end
    endcase
    cmdValid = cv; cmdRead = rd; cmdIndex = idx; cmdWrData = cd;
    pcmValid = pv; pcmLeft = pl; pcmRight = pr;
    expTxQ.push_back({1'b1, cv, cv, pv, pv, 11'b0,
                      rd, idx, 12'b0, cd, 4'b0, pl, 4'b0, pr, 4'b0, 160'b0});
    ridx = 7'($urandom); rd16 = 16'($urandom); rl = 16'($urandom); rr = 16'($urandom);
    tag  = {1'($urandom), rv, 11'($urandom)};
    s1   = {1'($urandom), ridx, 12'($urandom)};
    s2   = {rd16, 4'($urandom)};
    s3   = {rl, 4'($urandom)};
    s4   = {rr, 4'($urandom)};
    junk = {$urandom, $urandom, $urandom, $urandom, $urandom};
    nextRx = {tag, s1, s2, s3, s4, junk};
    e.v = rv; e.idx = ridx; e.d = rd16; e.l = rl; e.r = rr;
    expRxQ.push_back(e);
  endtask

  // ---------------- monitor / scoreboard ----------------
  int   mpos = 0;
  bit   mStarted = 0;
  int   mframe = 0;
  logic mPrev = 1'b0;
  bit   syncBad = 0;
  logic [255:0] gotTx = '0;

  always @(negedge bitClk) begin
    if (rstN) begin
      if (syncOut === 1'b1 && mPrev !== 1'b1) begin
        mpos = 0;
        if (mStarted) mframe++;
        mStarted = 1;
      end else begin
        mpos = (mpos + 1) % 256;
      end
      mPrev = syncOut;
      if (mStarted) begin
        logic [3:0] gv;
        gv = {statIdxValid, statDataValid, recLeftValid, recRightValid};
        gotTx[255-mpos] = sdataOut;
        if (syncOut !== (mpos < 16)) syncBad = 1;
        if (mpos == 0) begin
          if (mframe == 0) begin
            chk(gv == 4'b0, "R2", "no strobe in first frame", 256'(gv), 256'(0));
          end else if (expRxQ.size() > 0) begin
            rxExp_t e;
            e = expRxQ.pop_front();
            chk(gv === e.v, "R9", "valid strobes gated by tag", 256'(gv), 256'(e.v));
            if (e.v[3]) chk(statIdx === e.idx, "R10", "status index", 256'(statIdx), 256'(e.idx));
            if (e.v[2]) chk(statData === e.d, "R8 R10", "status data", 256'(statData), 256'(e.d));
            if (e.v[1]) chk(recLeft === e.l, "R8 R10", "record left", 256'(recLeft), 256'(e.l));
            if (e.v[0]) chk(recRight === e.r, "R10", "record right", 256'(recRight), 256'(e.r));
          end
        end
        if (mpos == 1)
          chk(gv == 4'b0, "R9", "strobe one cycle wide", 256'(gv), 256'(0));
        if (mpos == 255) begin
          chk(!syncBad, "R1", "strobe high for positions 0..15 only", 256'(syncBad), 256'(0));
          syncBad = 0;
          if (expTxQ.size() > 0) begin
            logic [255:0] x;
            x = expTxQ.pop_front();
            chk(gotTx[255:240] === x[255:240], "R3", "tag", 256'(gotTx[255:240]), 256'(x[255:240]));
            chk(gotTx[239:200] === x[239:200], "R4", "command slots", 256'(gotTx[239:200]), 256'(x[239:200]));
            chk(gotTx[199:160] === x[199:160], "R5", "playback slots", 256'(gotTx[199:160]), 256'(x[199:160]));
            chk(gotTx[159:0] === x[159:0], "R6", "idle slots", 256'(gotTx[159:0]), 256'(x[159:0]));
            chk(gotTx === x, "R7", "frame unaffected by mid-frame input change", gotTx, x);
          end
        end
      end
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    loadFrame(0);
    repeat (3) @(posedge bitClk);
    @(negedge bitClk);
    chk(syncOut === 1'b0 && sdataOut === 1'b0, "R2", "outputs low in reset",
        256'({syncOut, sdataOut}), 256'(0));
    chk({statIdxValid, statDataValid, recLeftValid, recRightValid} === 4'b0, "R2",
        "strobes low in reset",
        256'({statIdxValid, statDataValid, recLeftValid, recRightValid}), 256'(0));
    @(posedge bitClk);
    #2 rstN = 1'b1;
    @(negedge bitClk);
    chk(syncOut === 1'b0, "R2", "strobe low before first edge", 256'(syncOut), 256'(0));
    @(negedge bitClk);
    chk(syncOut === 1'b1 && sdataOut === 1'b1, "R2", "first edge opens frame",
        256'({syncOut, sdataOut}), 256'(2'b11));
    for (int f = 1; f < NF; f++) begin
      do begin
        @(posedge bitClk);
        #2;
      end while (!(cStarted && cpos == 20));
      loadFrame(f);
    end
    while (expTxQ.size() > 0 || expRxQ.size() > 0) @(negedge bitClk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule